// File: doc/BRIEF.md
# Serial Port Interrupt and DMA Request Controller

This block gathers the status events of a serial port into a bank of sticky interrupt flags. It masks them with a per-source enable register and drives one combined interrupt line. Seven sources are tracked: transmit buffer empty, receive data ready, transmit finished, receive start detected, clear-to-send input changed, break received and error. Each source has a flag that is set by a one-cycle event pulse.

The enable mask is written through two strobed ports. One sets the bits written as 1 and the other clears them, so software never needs a read-modify-write. Both ports read back the same mask, which is brought out as a single output.

Two DMA request lines come out of the block. The transmit request follows the transmit-buffer-empty flag, and the receive request follows the receive-data-ready flag. Both are retired by the port's data-register accesses: a write to the data register retires the transmit request and a read retires the receive request. The other five flags are cleared by writing 1 to their bit of the flag register. Register decoding upstream of the block is reduced to write strobes carrying data.

Top module: `sirq_ctrl`

## Requirements
- R1: Flag bit positions are fixed: bit 0 transmit buffer empty, bit 1 receive data ready, bit 2 transmit finished, bit 3 receive start, bit 4 clear-to-send change, bit 5 break, bit 6 error. A pulse on `evt_i[k]` sets `flag_o[k]` at the next clock edge, and the flag stays set until it is cleared.
- R2: Writing the flag register (`flag_wr_i` high) with a 1 in bit 2 to 6 of `flag_wdata_i` clears that flag at the next edge. A 0 bit leaves its flag unchanged.
- R3: Flag bits 0 and 1 ignore flag-register writes. Bit 0 clears on a data-register write (`dreg_wr_i`). Bit 1 clears on a data-register read (`dreg_rd_i`).
- R4: When a set event and a clear (a flag write or a data-register access) reach the same flag in the same cycle, the flag is set afterwards.
- R5: A strobe on `ien_set_wr_i` sets every enable bit whose `ien_set_data_i` bit is 1. Zero bits have no effect.
- R6: A strobe on `ien_clr_wr_i` clears every enable bit whose `ien_clr_data_i` bit is 1. Zero bits have no effect. If both ports name the same bit in one cycle, the bit ends up set.
- R7: `ien_o` shows the current enable mask, with the same bit positions as the flags, for readback through either enable port.
- R8: `irq_o` is high in exactly those cycles where some flag and its enable are both set. It falls as soon as the flag is cleared or the enable is removed.
- R9: `tx_dma_req_o` equals flag bit 0 and `rx_dma_req_o` equals flag bit 1, independent of the enables. No other source affects the DMA lines.
- R10: After reset, all flags and enables are 0, and `irq_o` and both DMA requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | One-cycle event pulses, one per source |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 7 | Flag write data (1 clears) |
| ien_set_wr_i | input | 1 | Enable-set write strobe |
| ien_set_data_i | input | 7 | Enable-set data (1 enables) |
| ien_clr_wr_i | input | 1 | Enable-clear write strobe |
| ien_clr_data_i | input | 7 | Enable-clear data (1 disables) |
| dreg_wr_i | input | 1 | Data-register write strobe |
| dreg_rd_i | input | 1 | Data-register read strobe |
| flag_o | output | 7 | Current flags |
| ien_o | output | 7 | Current enable mask |
| irq_o | output | 1 | Combined interrupt request |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |

## Verification
Two collisions can fall in one cycle.

The first is a set event meeting a clear of the same flag. The bench provokes it by pulsing an event together with a write-1 to the flag register, and again by pulsing the transmit-empty event together with a data-register write. It judges that the flag is still set afterwards.

The second is the enable-set and enable-clear ports naming the same bit in one cycle. The bench judges that the bit stays enabled and that `irq_o` follows.

A scoreboard model, built from the requirements, predicts every output after each step.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int NSRC     = 7;
    localparam int SRC_TXE  = 0;
    localparam int SRC_RXR  = 1;
    localparam int SRC_TXF  = 2;
    localparam int SRC_RXS  = 3;
    localparam int SRC_CTS  = 4;
    localparam int SRC_BRK  = 5;
    localparam int SRC_ERR  = 6;
    localparam int NUM_STATUS_SRC = 2;
endpackage

// File: rtl/sirq_flag_bank.sv
module sirq_flag_bank
    import sirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         flag_wr_i,
    input  logic [N-1:0] flag_wdata_i,
    input  logic         dreg_wr_i,
    input  logic         dreg_rd_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } state_t;

    state_t st_d, st_q;
    logic [N-1:0] clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = '0;
        for (int i = 0; i < N; i++) begin
            if (i == SRC_TXE)
                clr_d[i] = dreg_wr_i;
            else if (i == SRC_RXR)
                clr_d[i] = dreg_rd_i;
            else
                clr_d[i] = flag_wr_i & flag_wdata_i[i];
            st_d.flag[i] = evt_i[i] | (st_q.flag[i] & ~clr_d[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_evt_sets_R1_R4: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> flag_o[g]);
        if (g >= NUM_STATUS_SRC) begin : g_w1c
            assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_wr_i && flag_wdata_i[g] && !evt_i[g]) |=> !flag_o[g]);
        end
    end

    assert_txe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i[SRC_TXE] && !dreg_wr_i) |=> $stable(flag_o[SRC_TXE]));
    assert_rxr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i[SRC_RXR] && !dreg_rd_i) |=> $stable(flag_o[SRC_RXR]));
endmodule

// File: rtl/sirq_enable_mask.sv
module sirq_enable_mask
    import sirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_wr_i,
    input  logic [N-1:0] set_data_i,
    input  logic         clr_wr_i,
    input  logic [N-1:0] clr_data_i,
    output logic [N-1:0] ien_o
);
    typedef struct packed {
        logic [N-1:0] ien;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr_i) st_d.ien = st_d.ien & ~clr_data_i;
        if (set_wr_i) st_d.ien = st_d.ien | set_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ien_o = st_q.ien;

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (set_wr_i && set_data_i[g]) |=> ien_o[g]);
        assert_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr_i && clr_data_i[g] && !(set_wr_i && set_data_i[g])) |=> !ien_o[g]);
        assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_wr_i && !clr_wr_i) |=> $stable(ien_o[g]));
    end
endmodule

// File: rtl/sirq_req_out.sv
module sirq_req_out
    import sirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         rst_n,
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] ien_i,
    output logic         irq_o,
    output logic         tx_dma_req_o,
    output logic         rx_dma_req_o
);
    logic [N-1:0] pend;

    always_comb begin
        pend         = flag_i & ien_i;
        irq_o        = |pend;
        tx_dma_req_o = flag_i[SRC_TXE];
        rx_dma_req_o = flag_i[SRC_RXR];
    end

    always_comb begin
        if (rst_n && ien_i == '0)
            assert_no_irq_masked_R8: assert (!irq_o);
        if (rst_n && flag_i == '0)
            assert_no_irq_clear_R8: assert (!irq_o);
    end
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
    import sirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         flag_wr_i,
    input  logic [N-1:0] flag_wdata_i,
    input  logic         ien_set_wr_i,
    input  logic [N-1:0] ien_set_data_i,
    input  logic         ien_clr_wr_i,
    input  logic [N-1:0] ien_clr_data_i,
    input  logic         dreg_wr_i,
    input  logic         dreg_rd_i,
    output logic [N-1:0] flag_o,
    output logic [N-1:0] ien_o,
    output logic         irq_o,
    output logic         tx_dma_req_o,
    output logic         rx_dma_req_o
);
    sirq_flag_bank #(.N(N)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
        .dreg_wr_i(dreg_wr_i), .dreg_rd_i(dreg_rd_i), .flag_o(flag_o)
    );

    sirq_enable_mask #(.N(N)) u_ien (
        .clk(clk), .rst_n(rst_n),
        .set_wr_i(ien_set_wr_i), .set_data_i(ien_set_data_i),
        .clr_wr_i(ien_clr_wr_i), .clr_data_i(ien_clr_data_i), .ien_o(ien_o)
    );

    sirq_req_out #(.N(N)) u_out (
        .rst_n(rst_n), .flag_i(flag_o), .ien_i(ien_o), .irq_o(irq_o),
        .tx_dma_req_o(tx_dma_req_o), .rx_dma_req_o(rx_dma_req_o)
    );

    assert_tx_dma_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dreg_wr_i && !evt_i[SRC_TXE]) |=> !tx_dma_req_o);
    assert_rx_dma_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dreg_rd_i && !evt_i[SRC_RXR]) |=> !rx_dma_req_o);
    assert_tx_dma_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[SRC_TXE] |=> tx_dma_req_o);
endmodule

// File: tb/sirq_ctrl_test.sv
module sirq_ctrl_test;
    localparam int N = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_i = '0, flag_wdata_i = '0, ien_set_data_i = '0, ien_clr_data_i = '0;
    logic         flag_wr_i = 1'b0, ien_set_wr_i = 1'b0, ien_clr_wr_i = 1'b0;
    logic         dreg_wr_i = 1'b0, dreg_rd_i = 1'b0;
    logic [N-1:0] flag_o, ien_o;
    logic         irq_o, tx_dma_req_o, rx_dma_req_o;

    sirq_ctrl #(.N(N)) uut (.*);

    always #5 clk = ~clk;

    typedef struct {
        string        tag;
        logic [N-1:0] flag;
        logic [N-1:0] ien;
        logic         irq;
        logic         tx;
        logic         rx;
    } exp_t;

    exp_t         sb[$];
    int           errors = 0;
    int           checks = 0;
    logic [N-1:0] mflag = '0, mien = '0;
    bit           done = 0;

    function automatic void compare(exp_t e);
        checks++;
        if (flag_o !== e.flag || ien_o !== e.ien || irq_o !== e.irq ||
            tx_dma_req_o !== e.tx || rx_dma_req_o !== e.rx) begin
            errors++;
            $display("FAIL %s: flag=%h ien=%h irq=%b tx=%b rx=%b expected flag=%h ien=%h irq=%b tx=%b rx=%b",
                     e.tag, flag_o, ien_o, irq_o, tx_dma_req_o, rx_dma_req_o,
                     e.flag, e.ien, e.irq, e.tx, e.rx);
        end
    endfunction

    task automatic step(input string tag, input logic [N-1:0] evt,
                        input logic fw, input logic [N-1:0] fwd,
                        input logic sw, input logic [N-1:0] sd,
                        input logic cw, input logic [N-1:0] cd,
                        input logic dw, input logic dr);
        exp_t e;
        @(negedge clk);
        evt_i = evt; flag_wr_i = fw; flag_wdata_i = fwd;
        ien_set_wr_i = sw; ien_set_data_i = sd;
        ien_clr_wr_i = cw; ien_clr_data_i = cd;
        dreg_wr_i = dw; dreg_rd_i = dr;
        for (int i = 0; i < N; i++) begin
            logic c;
            c = (i == 0) ? dw : (i == 1) ? dr : (fw && fwd[i]);
            if (c) mflag[i] = 1'b0;
            if (evt[i]) mflag[i] = 1'b1;
            if (cw && cd[i]) mien[i] = 1'b0;
            if (sw && sd[i]) mien[i] = 1'b1;
        end
        e.tag = tag; e.flag = mflag; e.ien = mien;
        e.irq = |(mflag & mien); e.tx = mflag[0]; e.rx = mflag[1];
        sb.push_back(e);
        @(negedge clk);
        evt_i = '0; flag_wr_i = 0; ien_set_wr_i = 0; ien_clr_wr_i = 0;
        dreg_wr_i = 0; dreg_rd_i = 0;
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        exp_t r;
        repeat (3) @(posedge clk);
        #2;
        r.tag = "R10 reset"; r.flag = '0; r.ien = '0; r.irq = 0; r.tx = 0; r.rx = 0;
        compare(r);
        rst_n = 1'b1;
        //        tag                           evt       fw fwd      sw sd       cw cd       dw dr
        step("R1 R9 all events",           7'h7f, 0, 7'h00, 0, 7'h00, 0, 7'h00, 0, 0);
        step("R2 R3 w1c all",              7'h00, 1, 7'h7f, 0, 7'h00, 0, 7'h00, 0, 0);
        step("R3 R9 data write",           7'h00, 0, 7'h00, 0, 7'h00, 0, 7'h00, 1, 0);
        step("R3 R9 data read",            7'h00, 0, 7'h00, 0, 7'h00, 0, 7'h00, 0, 1);
        step("R5 R7 enable set",           7'h00, 0, 7'h00, 1, 7'h14, 0, 7'h00, 0, 0);
        step("R1 R8 cts event irq",        7'h10, 0, 7'h00, 0, 7'h00, 0, 7'h00, 0, 0);
        step("R6 R8 enable clear",         7'h00, 0, 7'h00, 0, 7'h00, 1, 7'h10, 0, 0);
        step("R5 R8 re-enable",            7'h00, 0, 7'h00, 1, 7'h10, 0, 7'h00, 0, 0);
        step("R4 set beats w1c",           7'h10, 1, 7'h10, 0, 7'h00, 0, 7'h00, 0, 0);
        step("R2 R8 w1c drops irq",        7'h00, 1, 7'h10, 0, 7'h00, 0, 7'h00, 0, 0);
        step("R1 error event",             7'h40, 0, 7'h00, 0, 7'h00, 0, 7'h00, 0, 0);
        step("R2 zero write no effect",    7'h00, 1, 7'h00, 0, 7'h00, 0, 7'h00, 0, 0);
        step("R5 R6 zero enable data",     7'h00, 0, 7'h00, 1, 7'h00, 1, 7'h00, 0, 0);
        step("R6 R8 set and clear same",   7'h00, 0, 7'h00, 1, 7'h40, 1, 7'h40, 0, 0);
        step("R4 R9 txe event with write", 7'h01, 0, 7'h00, 0, 7'h00, 0, 7'h00, 1, 0);
        step("R3 w1c ignores bits 0 1",    7'h02, 0, 7'h00, 0, 7'h00, 0, 7'h00, 0, 0);
        step("R3 R9 flag write on 0 1",    7'h00, 1, 7'h03, 0, 7'h00, 0, 7'h00, 0, 0);
        step("R7 R8 clear all enables",    7'h00, 0, 7'h00, 0, 7'h00, 1, 7'h7f, 0, 0);
        step("R4 rxr event with read",     7'h02, 0, 7'h00, 0, 7'h00, 0, 7'h00, 0, 1);
        step("R8 R9 enable txe only",      7'h00, 0, 7'h00, 1, 7'h01, 0, 7'h00, 0, 0);
        step("R3 R8 data write drops irq", 7'h00, 0, 7'h00, 0, 7'h00, 0, 7'h00, 1, 0);
        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule